// File: doc/BRIEF.md
# Acquisition Trigger Unit

This block decides when an acquisition event begins. It watches a stream of signed ADC samples, each marked by a valid strobe, and an asynchronous external digital trigger line. Configuration inputs choose the trigger source (the external line or a threshold crossing on the sample stream), the threshold level, the crossing direction, and whether the unit fires once or re-arms itself. An arm pulse starts each run.

When the trigger is accepted, the unit sends a one-cycle pulse to the capture controller. It also drives a stretched copy of that pulse on a pin so that other acquisition devices can start from it. In level mode the threshold detector stays blind until an external edge enables it. This lets a shared, slow reference edge qualify fast local triggers. The capture controller sends back a busy flag and a window-done pulse. Triggers are ignored while busy is high. In repeating mode, window-done re-arms the unit. A two-bit state output and a wrapping trigger count report progress.

Top module: `acq_trigger_unit`

## Requirements
- R1: After reset, state_o is 0 (idle), and trig_o, trig_out_o and trig_cnt_o are 0.
- R2: In external mode (src_level_i=0), while the state is armed (2), a rising edge on ext_trig_i gives a trig_o pulse that lasts exactly one cycle. The pulse appears after the third rising clock edge that follows the input change: two synchronizer stages plus the output register. A falling edge or a steady level never fires.
- R3: In level mode (src_level_i=1) with the state armed, a valid sample fires when the previous valid sample and the current one straddle level_i. With slope_fall_i=0 the previous sample is below the level and the current one is at or above it. With slope_fall_i=1 the previous sample is at or above the level and the current one is below it. trig_o rises after the clock edge that takes the current sample.
- R4: In level mode, arm_i moves the state to waiting-for-enable (1). Crossings seen in that state are ignored. The next external rising edge moves the state to armed (2).
- R5: In single mode (multi_i=0), a fire moves the state to triggered (3). The state stays there, win_done_i has no effect, and no further trig_o occurs until arm_i.
- R6: In multiple mode (multi_i=1), win_done_i in the triggered state returns the state to armed (2) on the next cycle, in both source modes, with no new external enable needed.
- R7: While busy_i is high, trigger conditions in the armed state are dropped and not held for later.
- R8: trig_out_o rises in the same cycle as trig_o and stays high for PULSE_W cycles (default 4).
- R9: trig_cnt_o increases by one on every trig_o cycle, wraps modulo 2^CW, and holds otherwise.
- R10: arm_i, from any state, moves the state to 1 (level mode) or 2 (external mode) on the next cycle. It takes priority over a trigger condition in the same cycle, which then does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | DW | Signed ADC sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| src_level_i | input | 1 | 0 = external source, 1 = level crossing |
| level_i | input | DW | Signed threshold |
| slope_fall_i | input | 1 | 0 = rising crossing, 1 = falling crossing |
| multi_i | input | 1 | 0 = single, 1 = re-arm after each window |
| arm_i | input | 1 | Arm pulse |
| busy_i | input | 1 | Capture window in progress |
| win_done_i | input | 1 | Capture window complete pulse |
| trig_o | output | 1 | One-cycle trigger to the capture controller |
| trig_out_o | output | 1 | Stretched trigger for other devices |
| state_o | output | 2 | 0 idle, 1 waiting for enable, 2 armed, 3 triggered |
| trig_cnt_o | output | CW | Accepted trigger count |

## Verification
The assertions check, on every cycle, that each trigger is a single pulse issued only from the armed state and never while busy. They also check that the stretched output starts with it, that the count steps by exactly one per trigger, and that arm, single-mode hold and multi-mode re-arm move the state as required. Only the bench scenarios can show the exact trigger latency through the synchronizer and the full crossing rule. The bench covers that rule with a sweep over every pair of 4-bit samples, against several thresholds and both slopes. The bench scenarios also show that crossings before the enable edge and triggers during busy are truly lost and not delivered later.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ARMED  = 2'd2,
    ST_FIRED  = 2'd3
  } trig_state_e;
endpackage

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/level_cross.sv
module level_cross #(
  parameter int DW = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] smp_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] level_i,
  input  logic                 falling_i,
  output logic                 hit_o
);
  logic signed [DW-1:0] prev_q;
  logic                 prev_vld_q;
  logic                 above_now, above_prev;

  // previous sample is tracked always, so enabling loses no history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (vld_i) begin
      prev_q     <= smp_i;
      prev_vld_q <= 1'b1;
    end
  end

  assign above_now  = smp_i  >= level_i;
  assign above_prev = prev_q >= level_i;
  assign hit_o = vld_i & prev_vld_q &
                 (falling_i ? (above_prev & ~above_now) : (~above_prev & above_now));
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import acq_trig_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          src_level_i,
  input  logic          multi_i,
  input  logic          busy_i,
  input  logic          win_done_i,
  input  logic          ext_rise_i,
  input  logic          lvl_hit_i,
  output logic          fire_o,
  output logic [1:0]    state_o,
  output logic [CW-1:0] cnt_o
);
  trig_state_e state_q, state_d;
  logic        fire_d, fire_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    fire_d  = 1'b0;
    state_d = state_q;
    if (arm_i) begin
      state_d = src_level_i ? ST_WAIT : ST_ARMED;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_WAIT:  if (ext_rise_i) state_d = ST_ARMED;
        ST_ARMED: begin
          fire_d = ~busy_i & (src_level_i ? lvl_hit_i : ext_rise_i);
          if (fire_d) state_d = ST_FIRED;
        end
        ST_FIRED: if (multi_i && win_done_i) state_d = ST_ARMED;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
      if (fire_d) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign fire_o  = fire_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int TW = $clog2(PULSE_W + 1);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            left_q <= '0;
    else if (start_i)       left_q <= TW'(PULSE_W - 1);
    else if (left_q != '0)  left_q <= left_q - TW'(1);
  end

  assign pulse_o = start_i | (left_q != '0);
endmodule

// File: rtl/acq_trigger_unit.sv
module acq_trigger_unit #(
  parameter int DW      = 14,
  parameter int CW      = 16,
  parameter int SYNC_N  = 2,
  parameter int PULSE_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] smp_i,
  input  logic                 smp_vld_i,
  input  logic                 ext_trig_i,
  input  logic                 src_level_i,
  input  logic signed [DW-1:0] level_i,
  input  logic                 slope_fall_i,
  input  logic                 multi_i,
  input  logic                 arm_i,
  input  logic                 busy_i,
  input  logic                 win_done_i,
  output logic                 trig_o,
  output logic                 trig_out_o,
  output logic [1:0]           state_o,
  output logic [CW-1:0]        trig_cnt_o
);
  logic ext_rise, lvl_hit;

  ext_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .async_i(ext_trig_i), .rise_o(ext_rise)
  );

  level_cross #(.DW(DW)) u_lvl (
    .clk_i, .rst_ni, .smp_i, .vld_i(smp_vld_i), .level_i,
    .falling_i(slope_fall_i), .hit_o(lvl_hit)
  );

  trig_ctrl #(.CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .src_level_i, .multi_i, .busy_i, .win_done_i,
    .ext_rise_i(ext_rise), .lvl_hit_i(lvl_hit),
    .fire_o(trig_o), .state_o, .cnt_o(trig_cnt_o)
  );

  pulse_stretch #(.PULSE_W(PULSE_W)) u_out (
    .clk_i, .rst_ni, .start_i(trig_o), .pulse_o(trig_out_o)
  );
endmodule

// File: rtl/acq_trigger_chk.sv
module acq_trigger_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          arm_i,
  input logic          multi_i,
  input logic          busy_i,
  input logic          win_done_i,
  input logic          trig_o,
  input logic          trig_out_o,
  input logic [1:0]    state_o,
  input logic [CW-1:0] trig_cnt_o
);
  AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o); // R2
  AST_TRIG_FROM_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (state_o == 2'd3) && ($past(state_o) == 2'd2)); // R4
  AST_SINGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !multi_i && !arm_i) |=> (state_o == 2'd3 && !trig_o)); // R5
  AST_MULTI_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && multi_i && win_done_i && !arm_i) |=> state_o == 2'd2); // R6
  AST_NO_FIRE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !$past(busy_i)); // R7
  AST_OUT_WITH_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> trig_out_o); // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> trig_cnt_o == $past(trig_cnt_o) + CW'(1)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_o |-> $stable(trig_cnt_o)); // R9
  AST_ARM_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> ((state_o == 2'd1 || state_o == 2'd2) && !trig_o)); // R10
endmodule

bind acq_trigger_unit acq_trigger_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm_i), .multi_i(multi_i),
  .busy_i(busy_i), .win_done_i(win_done_i), .trig_o(trig_o),
  .trig_out_o(trig_out_o), .state_o(state_o), .trig_cnt_o(trig_cnt_o)
);

// File: tb/acq_trigger_unit_bench.sv
`timescale 1ns/1ps
module acq_trigger_unit_bench;
  localparam int DW = 4;
  localparam int CW = 8;
  localparam int PW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic signed [DW-1:0] smp_i = '0, level_i = '0;
  logic smp_vld_i = 0, ext_trig_i = 0, src_level_i = 0, slope_fall_i = 0;
  logic multi_i = 0, arm_i = 0, busy_i = 0, win_done_i = 0;
  logic trig_o, trig_out_o;
  logic [1:0] state_o;
  logic [CW-1:0] trig_cnt_o;

  int checks = 0, errors = 0, exp_cnt = 0;

  always #4 clk_i = ~clk_i;

  acq_trigger_unit #(.DW(DW), .CW(CW), .SYNC_N(2), .PULSE_W(PW)) u_acq_trigger_unit (
    .clk_i, .rst_ni, .smp_i, .smp_vld_i, .ext_trig_i, .src_level_i, .level_i,
    .slope_fall_i, .multi_i, .arm_i, .busy_i, .win_done_i,
    .trig_o, .trig_out_o, .state_o, .trig_cnt_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm_pulse();
    arm_i = 1; nclk(); arm_i = 0;
  endtask

  task automatic feed(input int v);
    smp_i = DW'(v); smp_vld_i = 1; nclk(); smp_vld_i = 0;
  endtask

  // returns trig_o seen three edges after the line rises
  task automatic ext_edge(output bit t);
    ext_trig_i = 1; nclk(3); t = trig_o; ext_trig_i = 0; nclk(3);
  endtask

  task automatic pulse_done();
    win_done_i = 1; nclk(); win_done_i = 0;
  endtask

  initial begin
    nclk(200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit t;
    nclk(3);
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 trig", trig_o, 0);
    chk("R1 trig_out", trig_out_o, 0);
    chk("R1 cnt", trig_cnt_o, 0);
    rst_ni = 1; nclk(2);
    chk("R1 state after release", state_o, 0);

    // external single
    src_level_i = 0; multi_i = 0;
    arm_pulse();
    chk("R10 arm ext -> armed", state_o, 2);
    ext_trig_i = 1; nclk(2);
    chk("R2 no trig before sync", trig_o, 0);
    nclk();
    chk("R2 trig at third edge", trig_o, 1);
    chk("R8 out starts with trig", trig_out_o, 1);
    chk("R5 state triggered", state_o, 3);
    exp_cnt++;
    nclk();
    chk("R2 single cycle", trig_o, 0);
    nclk(2);
    chk("R8 out last cycle", trig_out_o, 1);
    nclk();
    chk("R8 out ends after PULSE_W", trig_out_o, 0);
    ext_trig_i = 0; nclk(3);
    chk("R2 falling edge no trig", trig_o, 0);
    chk("R9 cnt", trig_cnt_o, exp_cnt);
    ext_edge(t);
    chk("R5 no retrigger in single", t, 0);
    pulse_done();
    chk("R5 win_done ignored in single", state_o, 3);

    // R10 arm restarts from triggered
    arm_pulse();
    chk("R10 rearm from triggered", state_o, 2);

    // external multiple, busy
    multi_i = 1;
    ext_edge(t);
    chk("R6 multi fire", t, 1); exp_cnt++;
    chk("R6 state triggered", state_o, 3);
    pulse_done();
    chk("R6 rearmed after window", state_o, 2);
    busy_i = 1;
    ext_edge(t);
    chk("R7 busy suppresses", t, 0);
    nclk(2); busy_i = 0; nclk(4);
    chk("R7 not queued", trig_o, 0);
    chk("R7 still armed", state_o, 2);
    ext_edge(t);
    chk("R7 fires after busy", t, 1); exp_cnt++;
    chk("R9 cnt", trig_cnt_o, exp_cnt);

    // level mode enable and ignore
    src_level_i = 1; level_i = 0; slope_fall_i = 0;
    arm_pulse();
    chk("R4 arm level -> wait", state_o, 1);
    feed(-5); feed(3);
    chk("R4 crossing ignored before enable", trig_o, 0);
    chk("R4 still waiting", state_o, 1);
    feed(-5);
    ext_edge(t);
    chk("R4 enable edge does not fire", t, 0);
    chk("R4 enabled -> armed", state_o, 2);
    // R10 arm beats a same-cycle crossing
    smp_i = 3; smp_vld_i = 1; arm_i = 1; nclk(); smp_vld_i = 0; arm_i = 0;
    chk("R10 arm priority no trig", trig_o, 0);
    chk("R10 arm priority state", state_o, 1);
    feed(-5);
    ext_edge(t);
    feed(3);
    chk("R3 level fire", trig_o, 1); exp_cnt++;
    pulse_done();
    chk("R6 level rearm skips enable", state_o, 2);
    feed(-5); feed(3);
    chk("R6 level refire", trig_o, 1); exp_cnt++;

    // R3 sweep over all 4-bit pairs, three levels, both slopes
    for (int li = 0; li < 3; li++) begin
      for (int sf = 0; sf < 2; sf++) begin
        for (int p = -8; p < 8; p++) begin
          for (int c = -8; c < 8; c++) begin
            int lv;
            bit e;
            lv = (li == 0) ? -3 : (li == 1) ? 0 : 5;
            level_i = DW'(lv); slope_fall_i = sf[0];
            e = sf ? (p >= lv && c < lv) : (p < lv && c >= lv);
            arm_pulse();
            feed(p);
            ext_edge(t);
            feed(c);
            chk($sformatf("R3 lv=%0d fall=%0d p=%0d c=%0d", lv, sf, p, c), trig_o, e);
            if (e) exp_cnt++;
          end
        end
      end
    end
    nclk();
    chk("R9 cnt wraps", trig_cnt_o, exp_cnt % (1 << CW));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule